// File: doc/BRIEF.md
# Tunnel Hop Router

This block is the forwarding stage of a tunnelling transport layer. Every adapter feeds packets into the router on its own valid/ready stream, and every packet begins with a header beat that carries a path identifier, the hop number, in its low bits. Each ingress adapter has a private route table, indexed by that hop number. Each table entry holds a valid flag, the egress adapter that should receive the packet, and the hop number to write into the forwarded header. The router never reads the tunnelled payload. It switches on the hop number and the table contents alone, so traffic from several native protocols can share the fabric at once, each on its own path.

A management agent that knows the whole topology writes the tables through a single write port. The router builds no routes of its own. A packet whose hop number selects an unprogrammed entry is taken in and thrown away, and a per-port counter records the loss. When several ingress adapters target one egress adapter, a rotating arbiter hands over the egress for one whole packet at a time.

Top module: `tunnel_hop_router`

## Requirements
- R1: After reset all egress streams are idle (`out_valid` low), all drop counters read zero, and every table entry is unprogrammed.
- R2: A packet entering port p with hop h, where p's entry h is valid, leaves on the egress adapter named by that entry, with every beat in order and the last flag on the final beat.
- R3: In the forwarded header beat (the first beat), bits [HOPW-1:0] are replaced by the entry's egress hop. All other header bits and all later beats pass unchanged.
- R4: A packet whose hop selects an invalid entry is accepted beat by beat and appears on no egress stream. That ingress port's drop counter (field p of `drop_cnt`, CNTW bits at offset p*CNTW) rises by one per packet.
- R5: A drop counter rises by exactly one per dropped packet and, in the default saturating build, stays at 2^CNTW-1 once it gets there.
- R6: When several ingress ports wait for the same egress, grants rotate in increasing port order starting after the last port served. A port is not served twice in a row while another port waits.
- R7: Packets are never interleaved. An egress carries the beats of one packet until its last beat, and at least one idle cycle separates two packets.
- R8: A table write takes effect from the next packet whose header is looked up after the write. A packet whose header lookup coincides with the write, or that is already in flight, keeps the old route.
- R9: Tables are per ingress port, so the same hop number on two ports can route to different egresses with different rewrites.
- R10: While `out_valid` is high and `out_ready` is low, the egress holds its valid, data and last values.
- R11: Packets bound for different egresses flow concurrently and independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_in_port | input | PW | Ingress port whose table is written |
| cfg_hop_idx | input | HOPW | Entry index (ingress hop) |
| cfg_entry_vld | input | 1 | Valid flag written to the entry |
| cfg_out_port | input | PW | Egress adapter written to the entry |
| cfg_out_hop | input | HOPW | Egress hop written to the entry |
| in_valid | input | NPORTS | Per-ingress beat valid |
| in_last | input | NPORTS | Per-ingress last beat of packet |
| in_data | input | NPORTS*DW | Per-ingress beat data, header hop in bits [HOPW-1:0] |
| in_ready | output | NPORTS | Per-ingress beat accepted |
| out_valid | output | NPORTS | Per-egress beat valid |
| out_last | output | NPORTS | Per-egress last beat |
| out_data | output | NPORTS*DW | Per-egress beat data |
| out_ready | input | NPORTS | Per-egress sink ready |
| drop_cnt | output | NPORTS*CNTW | Per-ingress dropped packet counters |

## Verification
The embedded properties assume well-behaved sources. Each ingress keeps its valid, data and last values unchanged until the beat is accepted, every packet closes with a last beat, and the management agent only writes egress numbers below NPORTS. The hold property on the egress side, and the single-owner property, depend on these conditions. The bench drives each port through one task that changes signals only after an accepted beat. It programs only existing egress numbers. It applies random sink backpressure on its own, so the source-side rules are never broken.

// File: rtl/tr_pkg.sv
package tr_pkg;
   typedef enum logic [1:0] {
      ING_IDLE = 2'd0,
      ING_FWD  = 2'd1,
      ING_DROP = 2'd2
   } ing_state_e;
endpackage

// File: rtl/tr_route_table.sv
module tr_route_table #(
   parameter int HOPW = 7,
   parameter int PW   = 2
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [HOPW-1:0] wr_idx,
   input  logic            wr_vld,
   input  logic [PW-1:0]   wr_port,
   input  logic [HOPW-1:0] wr_hop,
   input  logic [HOPW-1:0] rd_idx,
   output logic            rd_vld,
   output logic [PW-1:0]   rd_port,
   output logic [HOPW-1:0] rd_hop
);
   localparam int DEPTH = 1 << HOPW;
   localparam int EW    = 1 + PW + HOPW;

   logic [EW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[wr_idx] <= {wr_vld, wr_port, wr_hop};
      end
   end

   assign {rd_vld, rd_port, rd_hop} = mem[rd_idx];
endmodule

// File: rtl/tr_ingress.sv
module tr_ingress import tr_pkg::*; #(
   parameter int DW       = 32,
   parameter int HOPW     = 7,
   parameter int PW       = 2,
   parameter int CNTW     = 8,
   parameter bit SAT_DROP = 1'b1
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic            in_last,
   input  logic [DW-1:0]   in_data,
   output logic            in_ready,
   output logic [HOPW-1:0] lk_idx,
   input  logic            lk_vld,
   input  logic [PW-1:0]   lk_port,
   input  logic [HOPW-1:0] lk_hop,
   output logic            want,
   output logic [PW-1:0]   dst,
   output logic            fwd_valid,
   output logic            fwd_last,
   output logic [DW-1:0]   fwd_data,
   input  logic            fwd_ready,
   output logic [CNTW-1:0] drop_cnt
);
   ing_state_e      st;
   logic [PW-1:0]   dst_q;
   logic [HOPW-1:0] hop_q;
   logic            first_q;
   logic            hdr_drop;

   assign lk_idx   = in_data[HOPW-1:0];
   assign hdr_drop = (st == ING_IDLE) && in_valid && !lk_vld;

   always_comb begin
      case (st)
         ING_IDLE: in_ready = !lk_vld;
         ING_FWD:  in_ready = fwd_ready;
         ING_DROP: in_ready = 1'b1;
         default:  in_ready = 1'b0;
      endcase
   end

   assign want      = (st == ING_FWD);
   assign dst       = dst_q;
   assign fwd_valid = (st == ING_FWD) && in_valid;
   assign fwd_last  = in_last;
   assign fwd_data  = first_q ? {in_data[DW-1:HOPW], hop_q} : in_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ING_IDLE;
         dst_q   <= '0;
         hop_q   <= '0;
         first_q <= 1'b0;
      end else begin
         case (st)
            ING_IDLE: if (in_valid) begin
               if (lk_vld) begin
                  dst_q   <= lk_port;
                  hop_q   <= lk_hop;
                  first_q <= 1'b1;
                  st      <= ING_FWD;
               end else if (!in_last) begin
                  st <= ING_DROP;
               end
            end
            ING_FWD: if (in_valid && fwd_ready) begin
               first_q <= 1'b0;
               if (in_last) st <= ING_IDLE;
            end
            ING_DROP: if (in_valid && in_last) st <= ING_IDLE;
            default: st <= ING_IDLE;
         endcase
      end
   end

   if (SAT_DROP) begin : g_sat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) drop_cnt <= '0;
         else if (hdr_drop && (drop_cnt != '1)) drop_cnt <= drop_cnt + CNTW'(1);
      end

      p_cnt_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (drop_cnt == '1) |=> (drop_cnt == '1));
   end else begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) drop_cnt <= '0;
         else if (hdr_drop) drop_cnt <= drop_cnt + CNTW'(1);
      end
   end

   p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_cnt != $past(drop_cnt)) |-> (drop_cnt == $past(drop_cnt) + CNTW'(1)));

   p_route_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ING_FWD) && ($past(st) == ING_FWD)) |-> ($stable(dst_q) && $stable(hop_q)));
endmodule

// File: rtl/tr_egress_arb.sv
module tr_egress_arb #(
   parameter int NP     = 3,
   parameter int PW     = 2,
   parameter int DW     = 32,
   parameter int EGRESS = 0
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NP-1:0]   want,
   input  logic [NP*PW-1:0] dst,
   input  logic [NP-1:0]   fwd_valid,
   input  logic [NP-1:0]   fwd_last,
   input  logic [NP*DW-1:0] fwd_data,
   output logic [NP-1:0]   grant,
   output logic            out_valid,
   output logic            out_last,
   output logic [DW-1:0]   out_data,
   input  logic            out_ready
);
   logic [NP-1:0] req;
   logic          busy;
   logic [PW-1:0] owner, last_q, pick;
   int            idx;

   for (genvar i = 0; i < NP; i++) begin : g_req
      assign req[i]   = want[i] && (dst[i*PW +: PW] == PW'(EGRESS));
      assign grant[i] = busy && (owner == PW'(i)) && out_ready;
   end

   always_comb begin
      pick = last_q;
      idx  = 0;
      for (int k = NP; k >= 1; k--) begin
         idx = (int'(last_q) + k) % NP;
         if (req[idx]) pick = PW'(idx);
      end
   end

   assign out_valid = busy && fwd_valid[owner];
   assign out_last  = fwd_last[owner];
   assign out_data  = fwd_data[owner*DW +: DW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         owner  <= '0;
         last_q <= PW'(NP - 1);
      end else if (!busy) begin
         if (|req) begin
            busy   <= 1'b1;
            owner  <= pick;
            last_q <= pick;
         end
      end else if (out_valid && out_ready && out_last) begin
         busy <= 1'b0;
      end
   end

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

   p_pkt_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> !out_valid);

   p_rotate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && ($countones(req) > 1)) |=> (owner != $past(last_q)));
endmodule

// File: rtl/tunnel_hop_router.sv
module tunnel_hop_router #(
   parameter int NPORTS   = 3,
   parameter int DW       = 32,
   parameter int HOPW     = 7,
   parameter int CNTW     = 8,
   parameter bit SAT_DROP = 1'b1,
   localparam int PW      = (NPORTS > 1) ? $clog2(NPORTS) : 1
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [PW-1:0]          cfg_in_port,
   input  logic [HOPW-1:0]        cfg_hop_idx,
   input  logic                   cfg_entry_vld,
   input  logic [PW-1:0]          cfg_out_port,
   input  logic [HOPW-1:0]        cfg_out_hop,
   input  logic [NPORTS-1:0]      in_valid,
   input  logic [NPORTS-1:0]      in_last,
   input  logic [NPORTS*DW-1:0]   in_data,
   output logic [NPORTS-1:0]      in_ready,
   output logic [NPORTS-1:0]      out_valid,
   output logic [NPORTS-1:0]      out_last,
   output logic [NPORTS*DW-1:0]   out_data,
   input  logic [NPORTS-1:0]      out_ready,
   output logic [NPORTS*CNTW-1:0] drop_cnt
);
   if (NPORTS < 2) begin : g_chk_ports
      $error("NPORTS must be at least 2");
   end
   if (DW <= HOPW) begin : g_chk_width
      $error("DW must exceed HOPW");
   end
   if (CNTW < 1) begin : g_chk_cnt
      $error("CNTW must be positive");
   end

   logic [NPORTS-1:0]    want, fwd_valid, fwd_last, fwd_ready;
   logic [NPORTS*PW-1:0] dst;
   logic [NPORTS*DW-1:0] fwd_data;
   logic [NPORTS-1:0]    gnt [NPORTS];
   logic [NPORTS-1:0]    col [NPORTS];

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      logic [HOPW-1:0] lk_idx, lk_hop;
      logic            lk_vld;
      logic [PW-1:0]   lk_port;

      tr_route_table #(.HOPW(HOPW), .PW(PW)) u_tbl (
         .clk(clk), .rst_n(rst_n),
         .wr_en(cfg_we && (cfg_in_port == PW'(p))),
         .wr_idx(cfg_hop_idx), .wr_vld(cfg_entry_vld),
         .wr_port(cfg_out_port), .wr_hop(cfg_out_hop),
         .rd_idx(lk_idx), .rd_vld(lk_vld), .rd_port(lk_port), .rd_hop(lk_hop)
      );

      tr_ingress #(.DW(DW), .HOPW(HOPW), .PW(PW), .CNTW(CNTW), .SAT_DROP(SAT_DROP)) u_ing (
         .clk(clk), .rst_n(rst_n),
         .in_valid(in_valid[p]), .in_last(in_last[p]),
         .in_data(in_data[p*DW +: DW]), .in_ready(in_ready[p]),
         .lk_idx(lk_idx), .lk_vld(lk_vld), .lk_port(lk_port), .lk_hop(lk_hop),
         .want(want[p]), .dst(dst[p*PW +: PW]),
         .fwd_valid(fwd_valid[p]), .fwd_last(fwd_last[p]),
         .fwd_data(fwd_data[p*DW +: DW]), .fwd_ready(fwd_ready[p]),
         .drop_cnt(drop_cnt[p*CNTW +: CNTW])
      );

      tr_egress_arb #(.NP(NPORTS), .PW(PW), .DW(DW), .EGRESS(p)) u_arb (
         .clk(clk), .rst_n(rst_n),
         .want(want), .dst(dst), .fwd_valid(fwd_valid), .fwd_last(fwd_last),
         .fwd_data(fwd_data), .grant(gnt[p]),
         .out_valid(out_valid[p]), .out_last(out_last[p]),
         .out_data(out_data[p*DW +: DW]), .out_ready(out_ready[p])
      );
   end

   always_comb begin
      for (int i = 0; i < NPORTS; i++) begin
         for (int e = 0; e < NPORTS; e++) col[i][e] = gnt[e][i];
         fwd_ready[i] = |col[i];
      end
   end

   for (genvar i = 0; i < NPORTS; i++) begin : g_own
      p_single_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(col[i]));
   end
endmodule

// File: tb/test_tunnel_hop_router.sv
`timescale 1ns/1ps
module test_tunnel_hop_router;
   localparam int NP   = 3;
   localparam int DW   = 32;
   localparam int HOPW = 7;
   localparam int CNTW = 8;
   localparam int PW   = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [PW-1:0] cfg_in_port = '0, cfg_out_port = '0;
   logic [HOPW-1:0] cfg_hop_idx = '0, cfg_out_hop = '0;
   logic cfg_entry_vld = 1'b0;
   logic [NP-1:0] in_valid = '0, in_last = '0, in_ready;
   logic [NP*DW-1:0] in_data = '0;
   logic [NP-1:0] out_valid, out_last;
   logic [NP-1:0] out_ready = '1;
   logic [NP*DW-1:0] out_data;
   logic [NP*CNTW-1:0] drop_cnt;

   always #4 clk = ~clk;

   tunnel_hop_router #(.NPORTS(NP), .DW(DW), .HOPW(HOPW), .CNTW(CNTW)) i_tunnel_hop_router (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_in_port(cfg_in_port),
      .cfg_hop_idx(cfg_hop_idx), .cfg_entry_vld(cfg_entry_vld),
      .cfg_out_port(cfg_out_port), .cfg_out_hop(cfg_out_hop),
      .in_valid(in_valid), .in_last(in_last), .in_data(in_data), .in_ready(in_ready),
      .out_valid(out_valid), .out_last(out_last), .out_data(out_data),
      .out_ready(out_ready), .drop_cnt(drop_cnt)
   );

   int n_chk = 0, n_fail = 0, seqn = 0;
   bit bp_en = 1'b0, done = 1'b0;
   logic [DW:0] expq [NP*NP][$];
   int log_src [NP][$];

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] mk(int p, int s, int k, logic [HOPW-1:0] hop);
      logic [DW-1:0] d;
      logic [7:0] kb = k[7:0];
      d = {p[1:0], s[5:0], kb, 16'h0};
      if (k == 0) d[HOPW-1:0] = hop;
      else d[15:0] = {8'hC3, kb};
      return d;
   endfunction

   function automatic int pending();
      int n = 0;
      for (int i = 0; i < NP*NP; i++) n += expq[i].size();
      return n;
   endfunction

   task automatic wr(int p, int h, bit v, int eg, int eh);
      @(negedge clk);
      cfg_we = 1'b1; cfg_in_port = PW'(p); cfg_hop_idx = HOPW'(h);
      cfg_entry_vld = v; cfg_out_port = PW'(eg); cfg_out_hop = HOPW'(eh);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic send(int p, int hop, int nb, int eg, int ehop, bit drop);
      int s = seqn;
      seqn++;
      for (int k = 0; k < nb; k++) begin
         logic [DW-1:0] d = mk(p, s, k, HOPW'(hop));
         if (k == 0) d[HOPW-1:0] = HOPW'(ehop);
         if (!drop) expq[eg*NP+p].push_back({k == nb-1, d});
      end
      for (int k = 0; k < nb; k++) begin
         @(negedge clk);
         in_valid[p] = 1'b1;
         in_last[p]  = (k == nb-1);
         in_data[p*DW +: DW] = mk(p, s, k, HOPW'(hop));
         #1;
         while (!in_ready[p]) begin
            @(negedge clk);
            #1;
         end
         @(posedge clk);
      end
      @(negedge clk);
      in_valid[p] = 1'b0;
      in_last[p]  = 1'b0;
   endtask

   task automatic drain();
      while (pending() > 0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      forever begin
         @(negedge clk);
         for (int e = 0; e < NP; e++) out_ready[e] = bp_en ? (($urandom % 4) != 0) : 1'b1;
      end
   end

   for (genvar e = 0; e < NP; e++) begin : g_mon
      initial begin
         logic [1:0] cur_src = '0;
         bit in_pkt = 1'b0, prev_stall = 1'b0;
         logic [DW:0] prev_beat = '0, beat, exp;
         forever begin
            @(negedge clk);
            #2;
            if (!rst_n) continue;
            beat = {out_last[e], out_data[e*DW +: DW]};
            if (prev_stall)
               chk(out_valid[e] && (beat == prev_beat), "R10", "stalled beat held", beat, prev_beat);
            prev_stall = out_valid[e] && !out_ready[e];
            prev_beat  = beat;
            if (out_valid[e] && out_ready[e]) begin
               if (!in_pkt) begin
                  cur_src = beat[DW-1 -: 2];
                  log_src[e].push_back(int'(cur_src));
               end else begin
                  chk(beat[DW-1 -: 2] == cur_src, "R7", "no interleave", beat[DW-1 -: 2], cur_src);
               end
               if (expq[e*NP+cur_src].size() == 0) begin
                  chk(1'b0, "R4", "unexpected beat on egress", beat, 0);
               end else begin
                  exp = expq[e*NP+cur_src].pop_front();
                  chk(beat == exp, in_pkt ? "R2" : "R3", "forwarded beat", beat, exp);
               end
               in_pkt = !out_last[e];
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #2;
      // R1: reset state
      chk(out_valid == '0, "R1", "out_valid after reset", out_valid, 0);
      chk(drop_cnt == '0, "R1", "drop counters after reset", drop_cnt, 0);

      // Program routes (R9: hop 8 differs per port)
      wr(0, 8, 1, 1, 20);
      wr(1, 8, 1, 2, 33);
      wr(2, 9, 1, 0, 9);
      wr(0, 9, 1, 2, 127);
      wr(1, 0, 1, 0, 0);
      wr(2, 127, 1, 1, 5);

      // R2 R3 R9: single packets of several lengths
      send(0, 8, 1, 1, 20, 0);
      send(1, 8, 3, 2, 33, 0);
      send(0, 9, 5, 2, 127, 0);
      send(1, 0, 2, 0, 0, 0);
      send(2, 127, 4, 1, 5, 0);
      drain();
      chk(pending() == 0, "R2", "all single packets delivered", pending(), 0);

      // R11: concurrent traffic to distinct egresses, with backpressure
      bp_en = 1'b1;
      fork
         send(0, 8, 4, 1, 20, 0);
         send(1, 8, 3, 2, 33, 0);
         send(2, 9, 5, 0, 9, 0);
      join
      drain();
      chk(pending() == 0, "R11", "concurrent packets delivered", pending(), 0);

      // R4: drops on unprogrammed hop, then on an invalidated entry
      send(1, 50, 3, 0, 0, 1);
      send(1, 51, 1, 0, 0, 1);
      wr(2, 127, 0, 1, 5);
      send(2, 127, 2, 0, 0, 1);
      repeat (10) @(negedge clk);
      #2;
      chk(drop_cnt[1*CNTW +: CNTW] == 2, "R4", "port1 drop count", drop_cnt[1*CNTW +: CNTW], 2);
      chk(drop_cnt[2*CNTW +: CNTW] == 1, "R4", "port2 drop count", drop_cnt[2*CNTW +: CNTW], 1);
      chk(drop_cnt[0 +: CNTW] == 0, "R4", "port0 untouched", drop_cnt[0 +: CNTW], 0);
      chk(pending() == 0, "R4", "nothing pending after drops", pending(), 0);

      // R6: three ports contend for egress 0; last owner of egress 0 was port 2
      wr(0, 10, 1, 0, 11);
      wr(1, 10, 1, 0, 12);
      wr(2, 10, 1, 0, 13);
      log_src[0].delete();
      fork
         begin send(0, 10, 3, 0, 11, 0); send(0, 10, 3, 0, 11, 0); end
         begin send(1, 10, 3, 0, 12, 0); send(1, 10, 3, 0, 12, 0); end
         begin send(2, 10, 3, 0, 13, 0); send(2, 10, 3, 0, 13, 0); end
      join
      drain();
      chk(log_src[0].size() == 6, "R6", "packet count on egress 0", log_src[0].size(), 6);
      for (int i = 0; i < 6 && i < log_src[0].size(); i++)
         chk(log_src[0][i] == (i % 3), "R6", "rotation order", log_src[0][i], i % 3);

      // R8: write during an in-flight packet
      fork
         send(0, 8, 6, 1, 20, 0);
         begin repeat (4) @(negedge clk); wr(0, 8, 1, 0, 77); end
      join
      send(0, 8, 2, 0, 77, 0);
      // R8: write landing on the same edge as the header lookup
      fork
         wr(0, 8, 1, 2, 3);
         send(0, 8, 2, 0, 77, 0);
      join
      send(0, 8, 3, 2, 3, 0);
      drain();
      chk(pending() == 0, "R8", "routes follow write timing", pending(), 0);

      // R5: saturation of the port 0 drop counter
      bp_en = 1'b0;
      for (int i = 0; i < 255; i++) send(0, 99, 1, 0, 0, 1);
      repeat (3) @(negedge clk); #2;
      chk(drop_cnt[0 +: CNTW] == 255, "R5", "count reaches max", drop_cnt[0 +: CNTW], 255);
      for (int i = 0; i < 5; i++) send(0, 99, 1, 0, 0, 1);
      repeat (3) @(negedge clk); #2;
      chk(drop_cnt[0 +: CNTW] == 255, "R5", "count saturates", drop_cnt[0 +: CNTW], 255);
      chk(drop_cnt[1*CNTW +: CNTW] == 2, "R5", "other counter unchanged", drop_cnt[1*CNTW +: CNTW], 2);
      chk(out_valid == '0, "R4", "no egress activity after drops", out_valid, 0);

      drain();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule